// File: doc/BRIEF.md
# Configuration Packet Stream Processor

The block takes a stream of 32-bit configuration words on a valid/ready input. While unsynchronized it discards every word until the 32-bit synchronization pattern 0xAA995566 arrives. From then on, each word that is not payload is decoded as a type-1 packet header. Such a header names an operation, a register address and a word count.

A read header sends the addressed register out on a separate valid/ready output stream, once per counted word. A write header stores the next counted words into the addressed register. Writing the value 0x0000000D to the command register drops the block back into sync hunting. The register set is small and internal. One identification register is read-only and takes its value from a parameter.

Top module: `cfgp_top`

## Requirements
- R1: After reset, in_ready_o is 1, out_valid_o is 0, the block is unsynchronized and every writable register reads as zero.
- R2: While unsynchronized, every word except the sync word is ignored: all-ones padding, the bus-width markers 0x000000BB and 0x11220044, and well-formed read headers. No output is produced.
- R3: Receiving 0xAA995566 while unsynchronized makes the next accepted word decode as a header.
- R4: A header is recognised only when bits [31:29] equal 3'b001. Its opcode is in bits [28:27], its register address in bits [26:13] and its word count in bits [10:0]. Words with any other type field are ignored.
- R5: A header with opcode 2'b01 and word count N>0 produces exactly N output words, each holding the addressed register's value. The block then returns to header decoding.
- R6: A header with opcode 2'b10 and word count N>0 writes the next N input words to the addressed register in order, so the last one remains.
- R7: Headers with opcode 2'b00 or 2'b11, and headers with a zero word count (such as 0x20000000), access no register. The next word is decoded as a header.
- R8: Address 12 is read-only and always reads as the ID_VALUE parameter. Writes to it are ignored.
- R9: Addresses 19 and above read as zero, and writes to them are ignored.
- R10: While read data is pending, in_ready_o is 0. While out_valid_o is 1 and out_ready_i is 0, out_data_o holds its value.
- R11: Writing 0x0000000D to address 4 (the command register) stores the value and returns the block to sync hunting. Headers are then ignored until the sync word arrives again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_data_i | input | 32 | Configuration word |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| out_data_o | output | 32 | Read-back register value |
| out_valid_o | output | 1 | Read-back word valid |
| out_ready_i | input | 1 | Consumer accepts read-back word |

## Verification
The main stream is tried with several patterns. Pre-sync noise that includes a legal read header separates true sync gating from plain header filtering. Single and two-word reads and writes show that the word count is honoured and that the last write wins. Writes to the identification register and to an absent address, followed by reads, show that both are ignored. Opcode 00 and 11 headers, a zero-count read and a type-2 word, each followed by a read of a known register, show that none of them touches state or swallows the next header. A desynchronize write followed by a read that must stay silent, then a resync and a read of the command register, separates a real return to hunting from simple register storage. Directed tests add output back-pressure and a reset in mid-session.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_HDR, ST_WR, ST_RD} cfgp_state_e;
  localparam logic [31:0] SYNC_WORD   = 32'hAA99_5566;
  localparam logic [31:0] DESYNC_CODE = 32'h0000_000D;
  localparam logic [2:0]  HDR_TYPE1   = 3'b001;
  localparam logic [1:0]  OP_RD       = 2'b01;
  localparam logic [1:0]  OP_WR       = 2'b10;
  localparam int          ADDR_LSB    = 13;
endpackage

// File: rtl/cfgp_regfile.sv
module cfgp_regfile #(
  parameter int          NUM_REGS = 19,
  parameter int          ADDR_W   = 14,
  parameter int          ID_ADDR  = 12,
  parameter logic [31:0] ID_VALUE = 32'h1372_3093
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [31:0]       wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [31:0]       rdata_o
);
  logic [31:0] reg_v [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == ID_ADDR) begin : g_ro
      assign reg_v[i] = ID_VALUE;
    end else begin : g_rw
      logic [31:0] q_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_r <= '0;
        else if (we_i && waddr_i == ADDR_W'(i)) q_r <= wdata_i;
      end
      assign reg_v[i] = q_r;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (raddr_i == ADDR_W'(i)) rdata_o = reg_v[i];
  end
endmodule

// File: rtl/cfgp_parser.sv
module cfgp_parser
  import cfgp_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int WC_W     = 11,
  parameter int CMD_ADDR = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [31:0]       wdata_o
);
  cfgp_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WC_W-1:0]   cnt_q, cnt_d;
  logic              fire, desync;

  logic [2:0]        h_type;
  logic [1:0]        h_op;
  logic [ADDR_W-1:0] h_addr;
  logic [WC_W-1:0]   h_wc;

  assign h_type = in_data_i[31:29];
  assign h_op   = in_data_i[28:27];
  assign h_addr = in_data_i[ADDR_LSB +: ADDR_W];
  assign h_wc   = in_data_i[WC_W-1:0];

  assign in_ready_o  = (state_q != ST_RD);
  assign out_valid_o = (state_q == ST_RD);
  assign fire        = in_valid_i && in_ready_o;
  assign we_o        = fire && (state_q == ST_WR);
  assign wdata_o     = in_data_i;
  assign addr_o      = addr_q;
  assign desync      = we_o && addr_q == ADDR_W'(CMD_ADDR) && in_data_i == DESYNC_CODE;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_HUNT: if (fire && in_data_i == SYNC_WORD) state_d = ST_HDR;
      ST_HDR: begin
        if (fire && h_type == HDR_TYPE1 && h_wc != '0) begin
          addr_d = h_addr;
          cnt_d  = h_wc;
          if (h_op == OP_RD)      state_d = ST_RD;
          else if (h_op == OP_WR) state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (fire) begin
          cnt_d = cnt_q - 1'b1;
          if (desync)                 state_d = ST_HUNT;
          else if (cnt_q == WC_W'(1)) state_d = ST_HDR;
        end
      end
      ST_RD: begin
        if (out_ready_i) begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == WC_W'(1)) state_d = ST_HDR;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
    end
  end

  // R3
  sync_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT && in_valid_i && in_data_i == SYNC_WORD) |=> state_q == ST_HDR);
  // R11
  desync_hunt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR && in_valid_i && addr_q == ADDR_W'(CMD_ADDR) && in_data_i == DESYNC_CODE)
    |=> state_q == ST_HUNT);
  // R2
  hunt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HUNT |-> !out_valid_o && !we_o);
endmodule

// File: rtl/cfgp_top.sv
module cfgp_top #(
  parameter int          NUM_REGS = 19,
  parameter int          ADDR_W   = 14,
  parameter int          WC_W     = 11,
  parameter int          CMD_ADDR = 4,
  parameter int          ID_ADDR  = 12,
  parameter logic [31:0] ID_VALUE = 32'h1372_3093
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] in_data_i,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  output logic [31:0] out_data_o,
  output logic        out_valid_o,
  input  logic        out_ready_i
);
  logic [ADDR_W-1:0] addr;
  logic              we;
  logic [31:0]       wdata;

  cfgp_parser #(.ADDR_W(ADDR_W), .WC_W(WC_W), .CMD_ADDR(CMD_ADDR)) u_parser (
    .clk_i, .rst_ni, .in_data_i, .in_valid_i, .in_ready_o,
    .out_valid_o, .out_ready_i,
    .addr_o(addr), .we_o(we), .wdata_o(wdata)
  );

  cfgp_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .ID_ADDR(ID_ADDR),
                 .ID_VALUE(ID_VALUE)) u_regs (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(addr), .wdata_i(wdata),
    .raddr_i(addr), .rdata_o(out_data_o)
  );

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_data_o));
  // R10
  no_input_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);
  // R8
  id_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && addr == ADDR_W'(ID_ADDR)) |-> out_data_o == ID_VALUE);
endmodule

// File: tb/cfgp_top_test.sv
`timescale 1ns/1ps
module cfgp_top_test;
  localparam logic [31:0] ID = 32'hA363_1093;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cfgp_top #(.ID_VALUE(ID)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .out_data_o(out_data), .out_valid_o(out_valid),
    .out_ready_i(out_ready)
  );

  function automatic logic [31:0] hdr(logic [1:0] op, int addr, int wc);
    return {3'b001, op, 14'(addr), 2'b00, 11'(wc)};
  endfunction

  typedef struct packed {
    logic [31:0] w;
    logic [1:0]  n;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{32'hFFFF_FFFF,   2'd0, 32'h0,         4'd2},  // R2 padding
    '{32'h0000_00BB,   2'd0, 32'h0,         4'd2},  // R2 marker
    '{32'h1122_0044,   2'd0, 32'h0,         4'd2},  // R2 marker
    '{hdr(2'b01,7,1),  2'd0, 32'h0,         4'd2},  // R2 read before sync
    '{32'hFFFF_FFFF,   2'd0, 32'h0,         4'd2},
    '{32'hAA99_5566,   2'd0, 32'h0,         4'd3},  // R3 sync
    '{32'h2000_0000,   2'd0, 32'h0,         4'd7},  // R7 noop
    '{hdr(2'b01,12,1), 2'd1, ID,            4'd8},  // R8 R5
    '{hdr(2'b10,5,1),  2'd0, 32'h0,         4'd6},  // R6
    '{32'h1234_5678,   2'd0, 32'h0,         4'd6},
    '{hdr(2'b01,5,1),  2'd1, 32'h1234_5678, 4'd6},  // R6
    '{hdr(2'b10,9,2),  2'd0, 32'h0,         4'd6},
    '{32'h1111_1111,   2'd0, 32'h0,         4'd6},
    '{32'hCAFE_F00D,   2'd0, 32'h0,         4'd6},
    '{hdr(2'b01,9,2),  2'd2, 32'hCAFE_F00D, 4'd5},  // R5 two words, last write wins
    '{hdr(2'b10,12,1), 2'd0, 32'h0,         4'd8},
    '{32'hDEAD_BEEF,   2'd0, 32'h0,         4'd8},
    '{hdr(2'b01,12,1), 2'd1, ID,            4'd8},  // R8 write ignored
    '{hdr(2'b10,20,1), 2'd0, 32'h0,         4'd9},
    '{32'h5555_5555,   2'd0, 32'h0,         4'd9},
    '{hdr(2'b01,20,1), 2'd1, 32'h0,         4'd9},  // R9
    '{hdr(2'b00,5,1),  2'd0, 32'h0,         4'd7},  // R7 op 00
    '{hdr(2'b11,5,1),  2'd0, 32'h0,         4'd7},  // R7 op 11
    '{32'h4800_A001,   2'd0, 32'h0,         4'd4},  // R4 type field 010
    '{hdr(2'b01,5,1),  2'd1, 32'h1234_5678, 4'd7},  // R7 R4 state untouched
    '{hdr(2'b01,5,0),  2'd0, 32'h0,         4'd7},  // R7 zero count
    '{32'h3000_8001,   2'd0, 32'h0,         4'd11}, // R11 write cmd
    '{32'h0000_000D,   2'd0, 32'h0,         4'd11},
    '{hdr(2'b01,5,1),  2'd0, 32'h0,         4'd11}, // R11 ignored while hunting
    '{32'hAA99_5566,   2'd0, 32'h0,         4'd11},
    '{hdr(2'b01,4,1),  2'd1, 32'h0000_000D, 4'd11}  // R11 cmd value kept
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [31:0] w);
    @(negedge clk);
    in_data = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv(string tag, logic [31:0] exp);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    check(tag, out_data, exp);
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 in_ready", {31'b0, in_ready}, 32'd1);
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].w);
      if (VEC[i].n == 2'd0)
        check($sformatf("R%0d vec %0d no output", VEC[i].req, i), {31'b0, out_valid}, 32'd0);
      for (int k = 0; k < int'(VEC[i].n); k++)
        recv($sformatf("R%0d vec %0d data", VEC[i].req, i), VEC[i].exp);
      @(negedge clk);
      check($sformatf("R%0d vec %0d idle", VEC[i].req, i), {31'b0, out_valid}, 32'd0);
    end

    // R10 back-pressure: output held, input stalled
    send(32'hAA99_5566);
    send(hdr(2'b01, 5, 1));
    for (int k = 0; k < 3; k++) begin
      check("R10 valid held", {31'b0, out_valid}, 32'd1);
      check("R10 in_ready low", {31'b0, in_ready}, 32'd0);
      check("R10 data held", out_data, 32'h1234_5678);
      @(negedge clk);
    end
    recv("R10 data", 32'h1234_5678);

    // R1 mid-session reset clears registers and sync
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    send(hdr(2'b01, 5, 1));
    check("R1 unsynced after reset", {31'b0, out_valid}, 32'd0);
    send(32'hAA99_5566);
    send(hdr(2'b01, 5, 1));
    recv("R1 register cleared", 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule